// File: doc/BRIEF.md
# Patterned Line Draw Engine

This block draws a straight line of 16-bit pixels into a linear frame buffer. A start pulse loads the setup: the word address and half-word of the first pixel, the line stride in 32-bit words, a step direction for each axis, which axis is major, the pixel count and the per-step minor fraction. The engine then walks the line one major-axis pixel at a time. A 12-bit error accumulator, where 4096 stands for one whole pixel, decides when the minor axis also steps.

A 16-bit pattern with a 4-bit repeat count gives a dashed look. For each pixel the pattern bit chooses between the foreground colour and the off treatment. An off pixel is written with the background colour, or it is skipped so that the buffer keeps its old content. Each pixel write is one beat on a valid/ready port that carries a word address, data and byte enables. The busy output stays high for the whole draw. An interrupt, when enabled, marks a draw that reached its last pixel. A stop pulse ends a draw early at the next pixel boundary.

Top module: `pline_engine`

## Requirements
- R1: After reset, `busy`, `mem_valid` and `irq` are 0, and `mem_valid` stays 0 whenever `busy` is 0.
- R2: A pixel at column x and row y of the line goes to word address base + y*stride + x/2. Its byte enables are 4'b0011 when x is even and 4'b1100 when x is odd. The 16-bit colour is placed in both halves of `mem_data`. The start address inputs give base + y0*stride + x0/2 and x0 bit 0.
- R3: The first pixel is the start pixel. Each later pixel moves the major axis (X when `cfg_x_major`=1, else Y) by exactly one pixel. A direction bit of 1 increments that coordinate, and 0 decrements it; Y increments toward higher addresses. A length of N draws N+1 pixels.
- R4: The minor accumulator is 12 bits and is preset to 0x800 at start. After each pixel it adds `cfg_frac`. The minor coordinate of the next pixel steps once when that sum reaches 4096, and the accumulator keeps the sum modulo 4096.
- R5: Pixel k uses pattern bit i. i starts at `cfg_pat_cnt` and falls by one per pixel, wrapping from 0 back to `cfg_pat_cnt`. A bit of 1 writes `cfg_fg`. So 0x00FF with count 15 gives 8 off pixels, then 8 on pixels, then repeats.
- R6: An off pixel is written with `cfg_bg` when `cfg_bg_en`=1. When `cfg_bg_en`=0 the pixel issues no write, and the memory word stays unchanged.
- R7: While `mem_valid`=1 and `mem_ready`=0, the next cycle still has `mem_valid`=1 with the same address, data and byte enables.
- R8: `busy` rises the cycle after a `go` pulse taken while idle. It falls the cycle after the last pixel is accepted or skipped. A `go` pulse while busy is ignored.
- R9: `irq` rises together with the fall of `busy` when the draw reached its last pixel with `cfg_irq_en`=1. It stays 0 when `cfg_irq_en`=0, and it is cleared by the next accepted `go`.
- R10: A `stop` pulse during a draw ends it when the current pixel is accepted or skipped. Fewer pixels are written and `irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | Start pulse; loads all cfg inputs |
| stop | input | 1 | Abort pulse |
| cfg_start_word | input | AW | Word address of first pixel |
| cfg_start_half | input | 1 | Bit 0 of the first pixel's X |
| cfg_stride | input | SW | Line stride in 32-bit words |
| cfg_x_dir | input | 1 | 1: X increments |
| cfg_y_dir | input | 1 | 1: Y increments |
| cfg_x_major | input | 1 | 1: X is the major axis |
| cfg_len | input | LW | Pixel count minus 1 |
| cfg_frac | input | 12 | Minor step fraction per pixel |
| cfg_pattern | input | 16 | Dash pattern |
| cfg_pat_cnt | input | 4 | Highest pattern bit index used |
| cfg_fg | input | 16 | Foreground colour |
| cfg_bg | input | 16 | Background colour |
| cfg_bg_en | input | 1 | 1: off pixels get background |
| cfg_irq_en | input | 1 | 1: raise irq on completion |
| busy | output | 1 | Draw in progress |
| irq | output | 1 | Completion interrupt (level) |
| mem_valid | output | 1 | Write request |
| mem_ready | input | 1 | Write accepted |
| mem_addr | output | AW | Word address |
| mem_data | output | 32 | Write data |
| mem_be | output | 4 | Byte enables |

## Verification
The assertions assume that `mem_ready` may stall for any number of cycles but is eventually given. They also assume that `go` and `stop` are single-cycle pulses and that the cfg inputs are valid in the `go` cycle. The bench holds the cfg values steady around `go` and pulses the controls for exactly one cycle. It drives ready from a cycle counter that either always grants or withholds one cycle in three. It picks start points, strides and lengths so every line stays inside its memory model, so address wrap never comes into play.

// File: rtl/pline_pkg.sv
// Package: shared constants and types for the line draw engine.
// Assumes 16-bit pixels, two per 32-bit word, and a 12-bit error fraction.
package pline_pkg;
    localparam int FRAC_W    = 12;
    localparam logic [FRAC_W-1:0] FRAC_HALF = 12'h800;
    localparam int PIX_W     = 16;
    localparam int PAT_W     = 16;
    localparam int PAT_IW    = $clog2(PAT_W);

    typedef logic [PIX_W-1:0] pixel_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DRAW = 1'b1
    } draw_state_t;
endpackage

// File: rtl/pline_pattern.sv
// Module: pline_pattern
// Holds the dash pattern and walks a bit index down from the repeat count,
// wrapping back to it. Reports whether the current pixel is "on".
// Assumes load and adv are never high together.
module pline_pattern
    import pline_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv,
    input  logic [PAT_W-1:0]  pattern,
    input  logic [PAT_IW-1:0] cnt,
    output logic              pix_on
);
    logic [PAT_W-1:0]  pat_r;
    logic [PAT_IW-1:0] cnt_r;
    logic [PAT_IW-1:0] idx;

    // Latch pattern on load, step the bit index per pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pat_r <= '0;
            cnt_r <= '0;
            idx   <= '0;
        end else if (load) begin
            pat_r <= pattern;
            cnt_r <= cnt;
            idx   <= cnt;
        end else if (adv) begin
            idx <= (idx == '0) ? cnt_r : idx - 1'b1;
        end
    end

    // Select the current pattern bit.
    always_comb pix_on = pat_r[idx];

    assert_idx_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= cnt_r);
endmodule

// File: rtl/pline_walk.sv
// Module: pline_walk
// Tracks the pixel word address and half-word select. Steps the major axis
// every pixel and the minor axis on each carry of the 12-bit accumulator.
// Address arithmetic wraps modulo 2**AW; requires AW > SW.
module pline_walk
    import pline_pkg::*;
#(
    parameter int AW = 16,
    parameter int SW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv,
    input  logic [AW-1:0]     start_word,
    input  logic              start_half,
    input  logic [SW-1:0]     stride,
    input  logic              x_dir,
    input  logic              y_dir,
    input  logic              x_major,
    input  logic [FRAC_W-1:0] frac,
    output logic [AW-1:0]     word_addr,
    output logic              half
);
    logic [SW-1:0]     stride_r;
    logic              xd_r, yd_r, xm_r;
    logic [FRAC_W-1:0] frac_r;
    logic [FRAC_W-1:0] acc;
    logic [FRAC_W:0]   sum;
    logic              carry, x_step, y_step;
    logic [AW-1:0]     x_off, y_off, stride_w;

    // Accumulate the fraction and decide which axes step.
    always_comb begin
        sum      = {1'b0, acc} + {1'b0, frac_r};
        carry    = sum[FRAC_W];
        x_step   = xm_r ? 1'b1 : carry;
        y_step   = xm_r ? carry : 1'b1;
        stride_w = {{(AW-SW){1'b0}}, stride_r};
        if (!x_step)   x_off = '0;
        else if (xd_r) x_off = half ? {{(AW-1){1'b0}}, 1'b1} : '0;
        else           x_off = half ? '0 : {AW{1'b1}};
        if (!y_step)   y_off = '0;
        else if (yd_r) y_off = stride_w;
        else           y_off = '0 - stride_w;
    end

    // Load the start position or move to the next pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc       <= FRAC_HALF;
            word_addr <= '0;
            half      <= 1'b0;
            stride_r  <= '0;
            xd_r      <= 1'b0;
            yd_r      <= 1'b0;
            xm_r      <= 1'b0;
            frac_r    <= '0;
        end else if (load) begin
            acc       <= FRAC_HALF;
            word_addr <= start_word;
            half      <= start_half;
            stride_r  <= stride;
            xd_r      <= x_dir;
            yd_r      <= y_dir;
            xm_r      <= x_major;
            frac_r    <= frac;
        end else if (adv) begin
            acc       <= sum[FRAC_W-1:0];
            word_addr <= word_addr + x_off + y_off;
            if (x_step) half <= ~half;
        end
    end

    assert_half_major_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && xm_r) |=> (half != $past(half)));
endmodule

// File: rtl/pline_engine.sv
// Module: pline_engine (top)
// Patterned 16-bpp line draw engine with a single-beat valid/ready write port.
// Assumes go/stop are one-cycle pulses and cfg inputs are valid with go.
module pline_engine
    import pline_pkg::*;
#(
    parameter int AW = 16,
    parameter int SW = 12,
    parameter int LW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              stop,
    input  logic [AW-1:0]     cfg_start_word,
    input  logic              cfg_start_half,
    input  logic [SW-1:0]     cfg_stride,
    input  logic              cfg_x_dir,
    input  logic              cfg_y_dir,
    input  logic              cfg_x_major,
    input  logic [LW-1:0]     cfg_len,
    input  logic [FRAC_W-1:0] cfg_frac,
    input  logic [PAT_W-1:0]  cfg_pattern,
    input  logic [PAT_IW-1:0] cfg_pat_cnt,
    input  logic [PIX_W-1:0]  cfg_fg,
    input  logic [PIX_W-1:0]  cfg_bg,
    input  logic              cfg_bg_en,
    input  logic              cfg_irq_en,
    output logic              busy,
    output logic              irq,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_data,
    output logic [3:0]        mem_be
);
    draw_state_t state;
    logic [LW-1:0] rem;
    pixel_t        fg_r, bg_r;
    logic          bg_en_r, irq_en_r, abort_pend;
    logic          load, adv, pix_on, need_wr, half, finish, abort_now;
    logic [AW-1:0] word_addr;
    pixel_t        colour;

    // Control decode: start, per-pixel advance and end of draw.
    always_comb begin
        load      = (state == ST_IDLE) && go;
        need_wr   = pix_on || bg_en_r;
        adv       = (state == ST_DRAW) && (!need_wr || mem_ready);
        abort_now = abort_pend || stop;
        finish    = adv && ((rem == '0) || abort_now);
        colour    = pix_on ? fg_r : bg_r;
    end

    // State, pixel counter, abort request and interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            rem        <= '0;
            fg_r       <= '0;
            bg_r       <= '0;
            bg_en_r    <= 1'b0;
            irq_en_r   <= 1'b0;
            abort_pend <= 1'b0;
            irq        <= 1'b0;
        end else if (load) begin
            state      <= ST_DRAW;
            rem        <= cfg_len;
            fg_r       <= cfg_fg;
            bg_r       <= cfg_bg;
            bg_en_r    <= cfg_bg_en;
            irq_en_r   <= cfg_irq_en;
            abort_pend <= 1'b0;
            irq        <= 1'b0;
        end else if (state == ST_DRAW) begin
            if (stop) abort_pend <= 1'b1;
            if (finish) begin
                state <= ST_IDLE;
                irq   <= irq_en_r && !abort_now;
            end else if (adv) begin
                rem <= rem - 1'b1;
            end
        end
    end

    // Drive the write port from registered state only.
    always_comb begin
        busy      = (state == ST_DRAW);
        mem_valid = busy && need_wr;
        mem_addr  = word_addr;
        mem_data  = {colour, colour};
        mem_be    = half ? 4'b1100 : 4'b0011;
    end

    pline_pattern u_pattern (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .adv     (adv),
        .pattern (cfg_pattern),
        .cnt     (cfg_pat_cnt),
        .pix_on  (pix_on)
    );

    pline_walk #(.AW(AW), .SW(SW)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .adv        (adv),
        .start_word (cfg_start_word),
        .start_half (cfg_start_half),
        .stride     (cfg_stride),
        .x_dir      (cfg_x_dir),
        .y_dir      (cfg_y_dir),
        .x_major    (cfg_x_major),
        .frac       (cfg_frac),
        .word_addr  (word_addr),
        .half       (half)
    );

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_valid);
    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=>
            (mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_be)));
    assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && adv && rem != '0 && !abort_now) |=> (rem == $past(rem) - 1'b1));
    assert_irq_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $fell(busy));
    assert_abort_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && adv && abort_now) |=> (!busy && !irq));
endmodule

// File: tb/pline_engine_bench.sv
module pline_engine_bench;
    localparam int AW = 16, SW = 12, LW = 12;
    localparam int MEMW = 4096;
    localparam int STRIDE = 32;
    localparam int BASE = 100;
    localparam logic [15:0] FG = 16'hA5C3, BG = 16'h1234;

    typedef struct packed {
        logic [7:0]  x0;
        logic [7:0]  y0;
        logic        xd;
        logic        yd;
        logic        xm;
        logic [7:0]  len;
        logic [11:0] frac;
        logic [15:0] pat;
        logic [3:0]  cnt;
        logic        bgen;
        logic        irqen;
        logic        stall;
        logic [7:0]  exp_wr;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{8'd3,  8'd5,  1'b1, 1'b1, 1'b1, 8'd19, 12'h333, 16'h00FF, 4'hF, 1'b0, 1'b1, 1'b0, 8'd8},
        '{8'd30, 8'd20, 1'b0, 1'b0, 1'b1, 8'd19, 12'h800, 16'h00FF, 4'hF, 1'b1, 1'b0, 1'b1, 8'd20},
        '{8'd0,  8'd30, 1'b1, 1'b1, 1'b1, 8'd9,  12'h000, 16'hFFFF, 4'h0, 1'b0, 1'b1, 1'b1, 8'd10},
        '{8'd40, 8'd10, 1'b1, 1'b1, 1'b0, 8'd5,  12'hFFF, 16'h0005, 4'h2, 1'b0, 1'b0, 1'b0, 8'd4},
        '{8'd5,  8'd50, 1'b1, 1'b0, 1'b1, 8'd3,  12'h100, 16'h0000, 4'h3, 1'b0, 1'b1, 1'b1, 8'd0},
        '{8'd50, 8'd60, 1'b0, 1'b0, 1'b0, 8'd7,  12'h555, 16'hFFFF, 4'hF, 1'b0, 1'b1, 1'b1, 8'd8}
    };

    logic clk = 1'b0, rst_n = 1'b0, go = 1'b0, stop = 1'b0;
    logic [AW-1:0] cfg_start_word = '0;
    logic cfg_start_half = 1'b0, cfg_x_dir = 1'b0, cfg_y_dir = 1'b0, cfg_x_major = 1'b0;
    logic [SW-1:0] cfg_stride = STRIDE;
    logic [LW-1:0] cfg_len = '0;
    logic [11:0] cfg_frac = '0;
    logic [15:0] cfg_pattern = '0, cfg_fg = FG, cfg_bg = BG;
    logic [3:0] cfg_pat_cnt = '0;
    logic cfg_bg_en = 1'b0, cfg_irq_en = 1'b0;
    logic busy, irq, mem_valid, mem_ready = 1'b1;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_data;
    logic [3:0] mem_be;

    int tests = 0, fails = 0, wr_count = 0, cyc = 0, stall_viol = 0;
    logic stall_mode = 1'b0, finished = 1'b0;
    logic [31:0] mem [MEMW];
    logic [31:0] exp_mem [MEMW];

    always #5 clk = ~clk;

    pline_engine #(.AW(AW), .SW(SW), .LW(LW)) u_pline_engine (
        .clk(clk), .rst_n(rst_n), .go(go), .stop(stop),
        .cfg_start_word(cfg_start_word), .cfg_start_half(cfg_start_half),
        .cfg_stride(cfg_stride), .cfg_x_dir(cfg_x_dir), .cfg_y_dir(cfg_y_dir),
        .cfg_x_major(cfg_x_major), .cfg_len(cfg_len), .cfg_frac(cfg_frac),
        .cfg_pattern(cfg_pattern), .cfg_pat_cnt(cfg_pat_cnt), .cfg_fg(cfg_fg),
        .cfg_bg(cfg_bg), .cfg_bg_en(cfg_bg_en), .cfg_irq_en(cfg_irq_en),
        .busy(busy), .irq(irq), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Memory model and stall monitor, evaluated between clock edges.
    logic        prev_stall = 1'b0;
    logic [AW-1:0] prev_addr;
    logic [31:0] prev_data;
    logic [3:0]  prev_be;
    always @(negedge clk) begin
        logic r;
        cyc++;
        r = stall_mode ? ((cyc % 3) != 0) : 1'b1;
        if (prev_stall && !(mem_valid && mem_addr == prev_addr &&
                            mem_data == prev_data && mem_be == prev_be))
            stall_viol++;
        if (mem_valid && r) begin
            wr_count++;
            if (mem_be[0]) mem[mem_addr][15:0]  = mem_data[15:0];
            if (mem_be[2]) mem[mem_addr][31:16] = mem_data[31:16];
        end
        prev_stall = mem_valid && !r;
        prev_addr  = mem_addr;
        prev_data  = mem_data;
        prev_be    = mem_be;
        mem_ready  = r;
    end

    // Reference: coordinates, accumulator and pattern index per requirements.
    task automatic model(input vec_t v);
        int x, y, acc, idx, a;
        bit on;
        logic [15:0] c;
        x = v.x0; y = v.y0; acc = 'h800; idx = v.cnt;
        for (int k = 0; k <= v.len; k++) begin
            on = v.pat[idx];
            if (on || v.bgen) begin
                c = on ? FG : BG;
                a = BASE + y * STRIDE + x / 2;
                if (x % 2 == 1) exp_mem[a][31:16] = c;
                else            exp_mem[a][15:0]  = c;
            end
            acc = acc + v.frac;
            if (v.xm) begin
                x = v.xd ? x + 1 : x - 1;
                if (acc >= 4096) y = v.yd ? y + 1 : y - 1;
            end else begin
                y = v.yd ? y + 1 : y - 1;
                if (acc >= 4096) x = v.xd ? x + 1 : x - 1;
            end
            acc = acc % 4096;
            idx = (idx == 0) ? v.cnt : idx - 1;
        end
    endtask

    task automatic start(input vec_t v);
        @(negedge clk);
        cfg_start_word = AW'(BASE + v.y0 * STRIDE + v.x0 / 2);
        cfg_start_half = v.x0[0];
        cfg_x_dir = v.xd; cfg_y_dir = v.yd; cfg_x_major = v.xm;
        cfg_len = LW'(v.len); cfg_frac = v.frac;
        cfg_pattern = v.pat; cfg_pat_cnt = v.cnt;
        cfg_bg_en = v.bgen; cfg_irq_en = v.irqen;
        stall_mode = v.stall;
        wr_count = 0;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        #1_900_000;
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int n, bad;
        vec_t v;
        for (int i = 0; i < MEMW; i++) begin
            mem[i] = 32'hDEAD_BEEF ^ i;
            exp_mem[i] = 32'hDEAD_BEEF ^ i;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !mem_valid && !irq, "R1 reset outputs", {busy, mem_valid, irq}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !mem_valid, "R1 idle after reset", {busy, mem_valid}, 0);

        for (int t = 0; t < NV; t++) begin
            v = VECS[t];
            start(v);
            check(busy == 1'b1, "R8 busy after go", busy, 1);
            check(irq == 1'b0, "R9 irq cleared by go", irq, 0);
            model(v);
            wait_idle(n);
            check(!busy, "R8 busy falls at end", busy, 0);
            check(wr_count == v.exp_wr, "R3 R5 R6 write count", wr_count, v.exp_wr);
            bad = 0;
            for (int i = 0; i < MEMW; i++) if (mem[i] !== exp_mem[i]) bad++;
            check(bad == 0, "R2 R4 R5 R6 memory image", bad, 0);
            check(irq == v.irqen, "R9 irq at completion", irq, v.irqen);
        end
        check(stall_viol == 0, "R7 stable while stalled", stall_viol, 0);

        // R8: go while busy is ignored; R10: abort mid-draw
        v = VECS[2];
        v.len = 8'd200; v.x0 = 8'd0; v.y0 = 8'd40; v.irqen = 1'b1; v.stall = 1'b1;
        start(v);
        repeat (10) @(negedge clk);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        check(busy == 1'b1, "R8 go ignored while busy", busy, 1);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        wait_idle(n);
        check(!busy && n < 4, "R10 abort ends quickly", n, 0);
        check(irq == 1'b0, "R10 no irq on abort", irq, 0);
        check(wr_count > 0 && wr_count < 201, "R10 partial write count", wr_count, 10);
        check(stall_viol == 0, "R7 stable while stalled after abort", stall_viol, 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule